// File: doc/BRIEF.md
# Threshold-Based RTS/CTS Flow Controller

This block handles hardware handshaking for a serial port. On the receive side it compares the receive FIFO fill level against two programmable thresholds, a halt level and a resume level. It drives an RTS request high to ask the far end to stop sending, and drives it low again once the FIFO has drained far enough. Between the two levels the request keeps its last value, so it does not chatter as the level moves up and down by one.

On the transmit side the block synchronises the CTS input and produces a transmit-permit signal for the serializer. When CTS gating is enabled and CTS is high, new characters are held off. The permit changes only while the transmitter reports a character boundary, so a character already being shifted out is always finished. Each direction has its own enable, and both are off after reset. The FIFOs and the serializer sit outside this block.

Top module: `flow_handshake`

## Requirements
- R1: While reset (`rst_n` low) is asserted, and on the first cycle after it, `rts_req` is 0 and `tx_permit` is 1.
- R2: When `auto_rts_en` is 0 on a clock edge, `rts_req` is 0 after that edge, whatever the FIFO level.
- R3: When `auto_rts_en` is 1 and `rx_level` is at or above the halt threshold `thr_cfg[3:0]` on a clock edge, `rts_req` is 1 after that edge.
- R4: When `auto_rts_en` is 1, `rx_level` is below the halt threshold and at or below the resume threshold `thr_cfg[7:4]` on a clock edge, `rts_req` is 0 after that edge.
- R5: When `auto_rts_en` is 1 and `rx_level` lies strictly between the resume and halt thresholds, `rts_req` keeps its previous value.
- R6: If the resume threshold is at or above the halt threshold, a level at or above the halt threshold still gives `rts_req` = 1 (halt wins).
- R7: When `cts_gate_en` is 0 and `tx_idle` is 1 on a clock edge, `tx_permit` is 1 after that edge, whatever `cts_n_in` is.
- R8: With `cts_gate_en` = 1 and `tx_idle` = 1, `cts_n_in` passes through two synchronising flops: a change of `cts_n_in` shows on `tx_permit` (inverted: CTS high gives permit 0) after the third rising edge following the change.
- R9: While `tx_idle` is 0 on a clock edge, `tx_permit` keeps its value across that edge, so a character in progress is never cut off and gating starts only at a boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_level | input | LEVEL_W | Current receive FIFO fill level |
| thr_cfg | input | 2*TH_W | Thresholds: low nibble halt, high nibble resume |
| auto_rts_en | input | 1 | Enable automatic RTS control |
| cts_gate_en | input | 1 | Enable CTS gating of the transmitter |
| cts_n_in | input | 1 | CTS line from the far end, high means stop |
| tx_idle | input | 1 | Transmitter is at a character boundary |
| rts_req | output | 1 | RTS request, high asks the far end to stop |
| tx_permit | output | 1 | Transmitter may start a new character |

## Verification
The RTS request is due one rising edge after the level, thresholds and enable it depends on, and the transmit permit one edge after the enable and idle status, but three edges after a change of CTS because of the two synchronising flops. The bench drives every input on the falling edge, updates a reference model on the rising edge from the values it drove, and compares both outputs on the next falling edge, so each result is checked in exactly the cycle it is due. Directed sequences additionally confirm that the permit is still unchanged after the first and second edges following a CTS change and flips only after the third.

// File: rtl/flow_handshake.sv
module flow_handshake #(
  parameter int TH_W    = 4,
  parameter int LEVEL_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LEVEL_W-1:0]  rx_level,
  input  logic [2*TH_W-1:0]   thr_cfg,
  input  logic                auto_rts_en,
  input  logic                cts_gate_en,
  input  logic                cts_n_in,
  input  logic                tx_idle,
  output logic                rts_req,
  output logic                tx_permit
);
  logic [LEVEL_W-1:0] halt_lv, resume_lv;
  logic               at_halt, at_resume;
  logic [1:0]         cts_sync;
  logic               rts_q, permit_q;

  assign halt_lv   = LEVEL_W'(thr_cfg[TH_W-1:0]);
  assign resume_lv = LEVEL_W'(thr_cfg[2*TH_W-1:TH_W]);
  assign at_halt   = rx_level >= halt_lv;
  assign at_resume = rx_level <= resume_lv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           rts_q <= 1'b0;
    else if (!auto_rts_en) rts_q <= 1'b0;
    else if (at_halt)     rts_q <= 1'b1;
    else if (at_resume)   rts_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cts_sync <= 2'b00;
    else        cts_sync <= {cts_sync[0], cts_n_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       permit_q <= 1'b1;
    else if (tx_idle) permit_q <= !(cts_gate_en && cts_sync[1]);
  end

  assign rts_req   = rts_q;
  assign tx_permit = permit_q;
endmodule

// File: rtl/flow_handshake_chk.sv
module flow_handshake_chk #(
  parameter int TH_W    = 4,
  parameter int LEVEL_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [LEVEL_W-1:0] rx_level,
  input logic [2*TH_W-1:0]  thr_cfg,
  input logic               auto_rts_en,
  input logic               cts_gate_en,
  input logic               tx_idle,
  input logic               rts_req,
  input logic               tx_permit
);
  logic [LEVEL_W-1:0] h, r;
  assign h = LEVEL_W'(thr_cfg[TH_W-1:0]);
  assign r = LEVEL_W'(thr_cfg[2*TH_W-1:TH_W]);

  assert_rts_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_rts_en |=> !rts_req);
  assert_rts_halt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts_en && rx_level >= h) |=> rts_req);
  assert_rts_resume_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts_en && rx_level < h && rx_level <= r) |=> !rts_req);
  assert_rts_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts_en && rx_level < h && rx_level > r) |=> $stable(rts_req));
  assert_permit_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cts_gate_en && tx_idle) |=> tx_permit);
  assert_permit_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_idle |=> $stable(tx_permit));
endmodule

bind flow_handshake flow_handshake_chk #(.TH_W(TH_W), .LEVEL_W(LEVEL_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .thr_cfg(thr_cfg),
  .auto_rts_en(auto_rts_en), .cts_gate_en(cts_gate_en), .tx_idle(tx_idle),
  .rts_req(rts_req), .tx_permit(tx_permit)
);

// File: tb/test_flow_handshake.sv
module test_flow_handshake;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] rx_level = '0;
  logic [7:0] thr_cfg = '0;
  logic       auto_rts_en = 1'b0, cts_gate_en = 1'b0, cts_n_in = 1'b0, tx_idle = 1'b1;
  logic       rts_req, tx_permit;

  int n_run = 0, n_fail = 0, cycles = 0;
  logic m_rts = 1'b0, m_c1 = 1'b0, m_c2 = 1'b0, m_perm = 1'b1;
  string rts_tag = "R1", perm_tag = "R1";

  always #4 clk = ~clk;

  flow_handshake i_flow_handshake (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .thr_cfg(thr_cfg),
    .auto_rts_en(auto_rts_en), .cts_gate_en(cts_gate_en), .cts_n_in(cts_n_in),
    .tx_idle(tx_idle), .rts_req(rts_req), .tx_permit(tx_permit)
  );

  function automatic logic next_rts(logic prev, logic en, logic [3:0] lv, logic [7:0] t);
    if (!en) return 1'b0;
    if (lv >= t[3:0]) return 1'b1;
    if (lv <= t[7:4]) return 1'b0;
    return prev;
  endfunction

  function automatic string rts_req_tag(logic en, logic [3:0] lv, logic [7:0] t);
    if (!en) return "R2";
    if (lv >= t[3:0]) return (t[7:4] >= t[3:0]) ? "R6" : "R3";
    if (lv <= t[7:4]) return "R4";
    return "R5";
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rts <= 1'b0; m_c1 <= 1'b0; m_c2 <= 1'b0; m_perm <= 1'b1;
    end else begin
      m_rts <= next_rts(m_rts, auto_rts_en, rx_level, thr_cfg);
      rts_tag <= rts_req_tag(auto_rts_en, rx_level, thr_cfg);
      m_c1 <= cts_n_in; m_c2 <= m_c1;
      if (tx_idle) m_perm <= !(cts_gate_en && m_c2);
      perm_tag <= !tx_idle ? "R9" : (!cts_gate_en ? "R7" : "R8");
    end
  end

  task automatic check(string tag, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    cycles++;
    check(rts_tag, rts_req, m_rts);
    check(perm_tag, tx_permit, m_perm);
  endtask

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    check("R1 reset rts", rts_req, 1'b0);
    check("R1 reset permit", tx_permit, 1'b1);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1 first cycle rts", rts_req, 1'b0);
    check("R1 first cycle permit", tx_permit, 1'b1);

    // R3/R4/R5 directed hysteresis: halt 10, resume 4
    auto_rts_en = 1'b1; thr_cfg = 8'h4A;
    rx_level = 4'd7;  step(); check("R5 mid from low", rts_req, 1'b0);
    rx_level = 4'd10; step(); check("R3 at halt", rts_req, 1'b1);
    rx_level = 4'd7;  step(); check("R5 mid from high", rts_req, 1'b1);
    rx_level = 4'd5;  step(); check("R5 just above resume", rts_req, 1'b1);
    rx_level = 4'd4;  step(); check("R4 at resume", rts_req, 1'b0);
    // R6 inverted thresholds: halt 3, resume 9
    thr_cfg = 8'h93; rx_level = 4'd5; step(); check("R6 halt wins", rts_req, 1'b1);
    rx_level = 4'd2; step(); check("R6 below halt", rts_req, 1'b0);
    // R2 disabled
    rx_level = 4'd15; auto_rts_en = 1'b0; step(); check("R2 disabled", rts_req, 1'b0);

    // R8 latency
    cts_gate_en = 1'b1; tx_idle = 1'b1; cts_n_in = 1'b0; step(); step(); step();
    cts_n_in = 1'b1;
    step(); check("R8 edge1 still permit", tx_permit, 1'b1);
    step(); check("R8 edge2 still permit", tx_permit, 1'b1);
    step(); check("R8 edge3 blocked", tx_permit, 1'b0);
    // R9 boundary: CTS drops mid-character, permit waits for idle
    tx_idle = 1'b0; cts_n_in = 1'b0;
    step(); step(); step(); step(); check("R9 held mid character", tx_permit, 1'b0);
    tx_idle = 1'b1; step(); check("R9 released at boundary", tx_permit, 1'b1);
    // R9 CTS rises mid-character: character finishes
    tx_idle = 1'b0; cts_n_in = 1'b1;
    step(); step(); step(); step(); check("R9 not cut off", tx_permit, 1'b1);
    tx_idle = 1'b1; step(); check("R8 gated at boundary", tx_permit, 1'b0);
    // R7 gating disabled
    cts_gate_en = 1'b0; step(); check("R7 gate off", tx_permit, 1'b1);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      rx_level    = 4'($urandom);
      if ($urandom % 16 == 0) thr_cfg = 8'($urandom);
      if ($urandom % 32 == 0) auto_rts_en = ~auto_rts_en;
      if ($urandom % 32 == 0) cts_gate_en = ~cts_gate_en;
      if ($urandom % 8 == 0)  cts_n_in = ~cts_n_in;
      tx_idle = ($urandom % 3) != 0;
      step();
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule